// File: doc/BRIEF.md
# MSI Event Queue Controller

This block turns posted message-signalled interrupt writes into per-group interrupt events. Each incoming write carries an address offset and a 32-bit data word. The block decodes the target group from the offset. It stores the word in that group's circular queue, which lives in a shared internal RAM, and then advances the group's hardware-owned tail pointer. The group's interrupt line stays high while entries are pending.

Software uses a register port to program the per-group control registers and the shared interrupt-enable mask. It consumes entries by writing the group's head pointer. Through the same port it can read queue memory, either as stored or as a decoded vector index.

The write path is a three-state machine:

- `S_IDLE` accepts a write. It moves `S_IDLE -> S_STORE` when the write targets a valid, enabled group whose queue is not full. It stays in `S_IDLE` when the write is dropped or flagged.
- `S_STORE` writes the word into RAM. The transition `S_STORE -> S_BUMP` is unconditional.
- `S_BUMP` advances the tail. The transition `S_BUMP -> S_IDLE` is unconditional.

`msi_ready` is high only in `S_IDLE`.

Top module: `msi_evq_ctrl`

## Requirements
- R1: After reset, every control, head, tail, interrupt-enable and overflow register reads 0, all `irq` bits are low, and `msi_ready` is high.
- R2: The group index of an incoming write is `msi_addr >> 2` when `multi_region` is 0, and `msi_addr >> 12` when it is 1. A write whose index is 6 or more changes no state.
- R3: An accepted word is written to slot `tail` of its group before that tail advances. The tail becomes `(tail + 1) mod 64` three clock edges after acceptance, and `msi_ready` is low for the two cycles between.
- R4: Queue memory is read with `reg_addr[16]`=1. Bits [14:0] form the byte offset, and bit 15 selects the decoded view. The offset is group*256 + slot*4 when `multi_region` is 0, and group*4096 + slot*4 when it is 1. A multi-region offset whose in-page part is 256 or more reads 0.
- R5: `irq[g]` is high exactly when control bit 0, control bit 11 and interrupt-enable bit g are all set and head differs from tail. It falls on the edge that loads a head value equal to tail.
- R6: The head register takes the low 6 bits of a software write and reads back 6 bits. Software writes to a tail register are ignored.
- R7: A write to a disabled group (control bit 0 clear), or to a full group (tail + 1 equals head mod 64), is discarded without moving the tail. It sets bit g of the overflow register, which stays set until software writes 1 to that bit. Writing 0 has no effect.
- R8: The control register keeps only bit 0 (queue enable), bit 1 (per-event interrupt select) and bit 11 (interrupt enable). All other bits read 0.
- R9: A decoded-view read returns `(word >> 5) + (word & 31)` of the stored word.
- R10: The register window (`reg_addr[16]`=0) decodes `reg_addr[11:0]` as follows: interrupt enable at 0x208 (one bit per group), overflow at 0x20C, control n at 0x210+4n, head n at 0x250+8n, tail n at 0x254+8n. Read data is valid on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| multi_region | input | 1 | 0: word-stride groups; 1: 4 KB page-stride groups |
| msi_valid | input | 1 | Incoming MSI write strobe |
| msi_ready | output | 1 | Block can accept a write this cycle |
| msi_addr | input | 16 | MSI address offset |
| msi_data | input | 32 | MSI data word |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 17 | Bit 16 selects queue memory; bit 15 selects the decoded view |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 6 | Per-group interrupt level |

## Verification
The bench targets several corner cases:

- The wrap of the tail from 63 back to 0, and the one-slot-short full condition. A design that compares tail to head instead of tail+1 would overwrite unread entries or stop one entry early.
- Out-of-range group indices in both address modes. A design that truncated the index would silently land writes in groups 0 to 1.
- The overflow bit's write-1-to-clear rule, where a plain write would lose the flag or never clear it.
- The exact edge on which `irq` falls after a head update, and the masking of head writes to 6 bits.
- Decoded and multi-region memory reads, which catch a wrong shift or page stride.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_STORE = 2'd1,
        S_BUMP  = 2'd2
    } wr_state_e;

    localparam int unsigned CTRL_QEN_BIT = 0;
    localparam int unsigned CTRL_EVT_BIT = 1;
    localparam int unsigned CTRL_IEN_BIT = 11;

    localparam logic [11:0] INTEN_OFS = 12'h208;
    localparam logic [11:0] OVF_OFS   = 12'h20C;
    localparam int unsigned CTRL_BASE = 'h210;
    localparam int unsigned HEAD_BASE = 'h250;
    localparam int unsigned TAIL_BASE = 'h254;
    localparam int unsigned PAGE_SH   = 12;

    function automatic logic [31:0] vec_decode(input logic [31:0] w);
        return (w >> 5) + {27'd0, w[4:0]};
    endfunction

endpackage

// File: rtl/msi_evq_addr_dec.sv
module msi_evq_addr_dec #(
    parameter int unsigned NGRP      = 6,
    parameter int unsigned AW        = 16,
    parameter int unsigned GW        = 3,
    parameter int unsigned SH_SINGLE = 2,
    parameter int unsigned SH_MULTI  = 12
) (
    input  logic          multi,
    input  logic [AW-1:0] addr,
    output logic [GW-1:0] grp,
    output logic          hit
);

    logic [AW-1:0] idx;

    always_comb begin
        idx = multi ? (addr >> SH_MULTI) : (addr >> SH_SINGLE);
        hit = (idx < AW'(NGRP));
        grp = idx[GW-1:0];
    end

endmodule

// File: rtl/msi_evq_ram.sv
module msi_evq_ram #(
    parameter int unsigned DEPTH = 384,
    parameter int unsigned AW    = 9,
    parameter int unsigned DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/msi_evq_group.sv
module msi_evq_group
    import msi_evq_pkg::*;
#(
    parameter int unsigned PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [31:0]   ctrl_wdata,
    input  logic          head_we,
    input  logic [PW-1:0] head_wdata,
    input  logic          bump,
    input  logic          ovf_set,
    input  logic          ovf_clr,
    input  logic          inten,
    output logic [31:0]   ctrl_q,
    output logic [PW-1:0] head_q,
    output logic [PW-1:0] tail_q,
    output logic          ovf_q,
    output logic          qen,
    output logic          full,
    output logic          irq
);

    logic evt_q, ien_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qen    <= 1'b0;
            evt_q  <= 1'b0;
            ien_q  <= 1'b0;
            head_q <= '0;
            tail_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                qen   <= ctrl_wdata[CTRL_QEN_BIT];
                evt_q <= ctrl_wdata[CTRL_EVT_BIT];
                ien_q <= ctrl_wdata[CTRL_IEN_BIT];
            end
            if (head_we) head_q <= head_wdata;
            if (bump)    tail_q <= tail_q + 1'b1;
            if (ovf_set)      ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_q = '0;
        ctrl_q[CTRL_QEN_BIT] = qen;
        ctrl_q[CTRL_EVT_BIT] = evt_q;
        ctrl_q[CTRL_IEN_BIT] = ien_q;
        full = (PW'(tail_q + 1'b1) == head_q);
        irq  = qen && ien_q && inten && (head_q != tail_q);
    end

    // R3
    tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q != $past(tail_q)) |-> (tail_q == PW'($past(tail_q) + 1'b1)));

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(head_we) |-> (head_q == $past(head_q)));

    // R5
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(head_we) && ($past(head_wdata) == $past(tail_q)) && !$past(bump)) |-> !irq);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_q) && !$past(ovf_clr)) |-> ovf_q);

endmodule

// File: rtl/msi_evq_ctrl.sv
module msi_evq_ctrl
    import msi_evq_pkg::*;
#(
    parameter int unsigned NGRP   = 6,
    parameter int unsigned QDEPTH = 64,
    parameter int unsigned MSI_AW = 16,
    parameter int unsigned REG_AW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              multi_region,
    input  logic              msi_valid,
    output logic              msi_ready,
    input  logic [MSI_AW-1:0] msi_addr,
    input  logic [31:0]       msi_data,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NGRP-1:0]   irq
);

    localparam int unsigned PW         = $clog2(QDEPTH);
    localparam int unsigned GW         = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int unsigned MEM_DEPTH  = NGRP * QDEPTH;
    localparam int unsigned MAW        = $clog2(MEM_DEPTH);
    localparam int unsigned QBYTES     = QDEPTH * 4;
    localparam int unsigned QSH        = $clog2(QBYTES);
    localparam int unsigned WIN_W      = REG_AW - 2;

    // group state
    logic [31:0]     ctrl_v [NGRP];
    logic [PW-1:0]   head_v [NGRP];
    logic [PW-1:0]   tail_v [NGRP];
    logic [NGRP-1:0] full_v, qen_v, ovf_v;
    logic [NGRP-1:0] ctrl_we_v, head_we_v, bump_v, ovf_set_v, ovf_clr_v;
    logic [NGRP-1:0] inten_q;

    // write path
    wr_state_e       state_q, state_d;
    logic [GW-1:0]   msi_grp, cur_grp;
    logic            msi_hit, accept, ram_we;
    logic [PW-1:0]   cur_slot;
    logic [31:0]     cur_data;

    // register port
    logic            wr_reg, rd_any;
    logic [11:0]     rofs;
    logic [WIN_W-1:0] win_ofs;
    logic [GW-1:0]   win_grp;
    logic            win_hit, win_ok;
    logic [PW-1:0]   win_slot;
    logic [31:0]     rd_reg_val, reg_q, ram_q;
    logic            rd_mem_q, rd_dec_q, rd_ok_q;

    msi_evq_addr_dec #(
        .NGRP(NGRP), .AW(MSI_AW), .GW(GW), .SH_SINGLE(2), .SH_MULTI(PAGE_SH)
    ) u_msi_dec (
        .multi(multi_region), .addr(msi_addr), .grp(msi_grp), .hit(msi_hit)
    );

    assign win_ofs = reg_addr[WIN_W-1:0];

    msi_evq_addr_dec #(
        .NGRP(NGRP), .AW(WIN_W), .GW(GW), .SH_SINGLE(QSH), .SH_MULTI(PAGE_SH)
    ) u_win_dec (
        .multi(multi_region), .addr(win_ofs), .grp(win_grp), .hit(win_hit)
    );

    always_comb begin
        win_ok   = win_hit && (!multi_region || (win_ofs[PAGE_SH-1:0] < PAGE_SH'(QBYTES)));
        win_slot = PW'(win_ofs >> 2);
    end

    assign wr_reg = reg_en && reg_we && !reg_addr[REG_AW-1];
    assign rd_any = reg_en && !reg_we;
    assign rofs   = reg_addr[11:0];

    always_ff @(posedge clk) begin
        if (!rst_n)                        inten_q <= '0;
        else if (wr_reg && rofs == INTEN_OFS) inten_q <= reg_wdata[NGRP-1:0];
    end

    assign ovf_clr_v = (wr_reg && rofs == OVF_OFS) ? reg_wdata[NGRP-1:0] : '0;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign ctrl_we_v[g] = wr_reg && (rofs == 12'(CTRL_BASE + 4 * g));
        assign head_we_v[g] = wr_reg && (rofs == 12'(HEAD_BASE + 8 * g));

        msi_evq_group #(.PW(PW)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .ctrl_we(ctrl_we_v[g]), .ctrl_wdata(reg_wdata),
            .head_we(head_we_v[g]), .head_wdata(reg_wdata[PW-1:0]),
            .bump(bump_v[g]), .ovf_set(ovf_set_v[g]), .ovf_clr(ovf_clr_v[g]),
            .inten(inten_q[g]),
            .ctrl_q(ctrl_v[g]), .head_q(head_v[g]), .tail_q(tail_v[g]),
            .ovf_q(ovf_v[g]), .qen(qen_v[g]), .full(full_v[g]), .irq(irq[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign accept = (state_q == S_IDLE) && msi_valid && msi_hit;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = (accept && qen_v[msi_grp] && !full_v[msi_grp]) ? S_STORE : S_IDLE;
            S_STORE: state_d = S_BUMP;
            S_BUMP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs of the write path
    always_comb begin
        msi_ready = (state_q == S_IDLE);
        ram_we    = (state_q == S_STORE);
        bump_v    = '0;
        ovf_set_v = '0;
        if (state_q == S_BUMP) bump_v[cur_grp] = 1'b1;
        if (accept && (!qen_v[msi_grp] || full_v[msi_grp])) ovf_set_v[msi_grp] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_grp  <= '0;
            cur_slot <= '0;
            cur_data <= '0;
        end else if (state_q == S_IDLE && state_d == S_STORE) begin
            cur_grp  <= msi_grp;
            cur_slot <= tail_v[msi_grp];
            cur_data <= msi_data;
        end
    end

    msi_evq_ram #(.DEPTH(MEM_DEPTH), .AW(MAW), .DW(32)) u_ram (
        .clk(clk),
        .we(ram_we),
        .waddr(MAW'(cur_grp) * MAW'(QDEPTH) + MAW'(cur_slot)),
        .wdata(cur_data),
        .re(rd_any && reg_addr[REG_AW-1]),
        .raddr(MAW'(win_grp) * MAW'(QDEPTH) + MAW'(win_slot)),
        .rdata(ram_q)
    );

    // register read decode
    always_comb begin
        rd_reg_val = '0;
        if (rofs == INTEN_OFS) rd_reg_val = 32'(inten_q);
        if (rofs == OVF_OFS)   rd_reg_val = 32'(ovf_v);
        for (int g = 0; g < NGRP; g++) begin
            if (rofs == 12'(CTRL_BASE + 4 * g)) rd_reg_val = ctrl_v[g];
            if (rofs == 12'(HEAD_BASE + 8 * g)) rd_reg_val = 32'(head_v[g]);
            if (rofs == 12'(TAIL_BASE + 8 * g)) rd_reg_val = 32'(tail_v[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q    <= '0;
            rd_mem_q <= 1'b0;
            rd_dec_q <= 1'b0;
            rd_ok_q  <= 1'b0;
        end else if (rd_any) begin
            reg_q    <= rd_reg_val;
            rd_mem_q <= reg_addr[REG_AW-1];
            rd_dec_q <= reg_addr[REG_AW-2];
            rd_ok_q  <= win_ok;
        end
    end

    always_comb begin
        if (!rd_mem_q)     reg_rdata = reg_q;
        else if (!rd_ok_q) reg_rdata = '0;
        else if (rd_dec_q) reg_rdata = vec_decode(ram_q);
        else               reg_rdata = ram_q;
    end

    // R3
    store_then_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STORE) |=> (state_q == S_BUMP));

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && full_v[msi_grp]) |=> (state_q == S_IDLE));

    // R2
    miss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && msi_valid && !msi_hit) |=> (state_q == S_IDLE));

endmodule

// File: tb/msi_evq_ctrl_test.sv
module msi_evq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        multi_region = 1'b0;
    logic        msi_valid = 1'b0;
    logic        msi_ready;
    logic [15:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [16:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    msi_evq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .multi_region(multi_region),
        .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_addr(msi_addr), .msi_data(msi_data),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // vectors: {msi address, data word, expected group (7 = dropped)}
    localparam logic [51:0] VEC [8] = '{
        {16'h0000, 32'h0000_0123, 4'd0},
        {16'h0004, 32'h0000_0040, 4'd1},
        {16'h0014, 32'h0000_0ABC, 4'd5},
        {16'h0008, 32'h0000_0007, 4'd2},
        {16'h0000, 32'h0000_0021, 4'd0},
        {16'h0018, 32'hDEAD_BEEF, 4'd7},
        {16'h0016, 32'h0000_0555, 4'd5},
        {16'h1000, 32'h0000_0077, 4'd7}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [16:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [16:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic send(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!msi_ready) @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_data = d;
        @(negedge clk);
        msi_valid = 1'b0;
        while (!msi_ready) @(negedge clk);
    endtask

    function automatic logic [16:0] memaddr(input bit multi, input int g, input int slot, input bit dec);
        logic [14:0] ofs;
        ofs = multi ? 15'(g * 4096 + slot * 4) : 15'(g * 256 + slot * 4);
        return {1'b1, dec, ofs};
    endfunction

    function automatic logic [16:0] tail_a(input int g);
        return 17'(12'h254 + 8 * g);
    endfunction

    function automatic logic [16:0] head_a(input int g);
        return 17'(12'h250 + 8 * g);
    endfunction

    function automatic logic [16:0] ctrl_a(input int g);
        return 17'(12'h210 + 4 * g);
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int exp_tail [6];
        foreach (exp_tail[i]) exp_tail[i] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 ready", 32'(msi_ready), 32'h1);
        reg_rd(tail_a(0), rd); chk("R1 tail0", rd, 32'h0);
        reg_rd(ctrl_a(3), rd); chk("R1 ctrl3", rd, 32'h0);
        reg_rd(17'h20C, rd);   chk("R1 ovf", rd, 32'h0);

        // R8 control bits, R10 interrupt enable register
        for (int g = 0; g < 6; g++) reg_wr(ctrl_a(g), 32'hFFFF_FFFF);
        reg_rd(ctrl_a(2), rd); chk("R8 ctrl2", rd, 32'h0000_0803);
        reg_wr(17'h208, 32'hFFFF_FFFF);
        reg_rd(17'h208, rd);   chk("R10 inten", rd, 32'h0000_003F);

        // vector table, single-region mode (R2, R3, R4)
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a;
            logic [31:0] d;
            int grp;
            a = VEC[i][51:36]; d = VEC[i][35:4]; grp = int'(VEC[i][3:0]);
            send(a, d);
            if (grp < 6) begin
                reg_rd(memaddr(0, grp, exp_tail[grp], 0), rd);
                chk("R4 stored word", rd, d);
                exp_tail[grp] = (exp_tail[grp] + 1) % 64;
                reg_rd(tail_a(grp), rd);
                chk("R3 tail advance", rd, 32'(exp_tail[grp]));
            end else begin
                reg_rd(17'h20C, rd);
                chk("R2 drop no ovf", rd, 32'h0);
                for (int g = 0; g < 6; g++) begin
                    reg_rd(tail_a(g), rd);
                    chk("R2 drop tail", rd, 32'(exp_tail[g]));
                end
            end
        end
        chk("R5 irq pending", 32'(irq), 32'h27);

        // R9 decoded view
        reg_rd(memaddr(0, 0, 0, 1), rd); chk("R9 decode 0x123", rd, 32'd12);
        reg_rd(memaddr(0, 0, 1, 1), rd); chk("R9 decode 0x21", rd, 32'd2);

        // R5 interrupt gating and drop timing
        reg_wr(17'h208, 32'h1F);
        chk("R5 inten masks", 32'(irq[5]), 32'h0);
        reg_wr(17'h208, 32'h3F);
        chk("R5 inten restore", 32'(irq[5]), 32'h1);
        reg_wr(ctrl_a(1), 32'h1);
        chk("R5 ien bit clear", 32'(irq[1]), 32'h0);
        reg_wr(ctrl_a(1), 32'h803);
        reg_wr(head_a(0), 32'd2);
        chk("R5 drop on head==tail", 32'(irq[0]), 32'h0);

        // R6 head mask, tail read-only
        reg_wr(head_a(1), 32'hFFFF_FFC1);
        reg_rd(head_a(1), rd); chk("R6 head mask", rd, 32'h1);
        chk("R6 irq1 after head", 32'(irq[1]), 32'h0);
        reg_wr(tail_a(2), 32'h3F);
        reg_rd(tail_a(2), rd); chk("R6 tail ignores write", rd, 32'h1);

        // R7 full queue on group 3
        for (int i = 0; i < 63; i++) send(16'h000C, 32'h1000 + 32'(i));
        reg_rd(tail_a(3), rd); chk("R7 tail before full", rd, 32'd63);
        send(16'h000C, 32'h0000_0BAD);
        reg_rd(tail_a(3), rd); chk("R7 full tail held", rd, 32'd63);
        reg_rd(17'h20C, rd);   chk("R7 ovf set", rd, 32'h08);
        reg_wr(17'h20C, 32'h0);
        reg_rd(17'h20C, rd);   chk("R7 ovf write0 keeps", rd, 32'h08);
        reg_wr(17'h20C, 32'h08);
        reg_rd(17'h20C, rd);   chk("R7 ovf w1c", rd, 32'h0);
        reg_rd(memaddr(0, 3, 62, 0), rd); chk("R7 last kept word", rd, 32'h1000 + 32'd62);
        reg_wr(head_a(3), 32'd10);
        send(16'h000C, 32'h0000_CAFE);
        reg_rd(tail_a(3), rd); chk("R3 tail wraps", rd, 32'h0);
        reg_rd(memaddr(0, 3, 63, 0), rd); chk("R3 slot 63 word", rd, 32'h0000_CAFE);

        // R7 disabled group
        reg_wr(ctrl_a(4), 32'h0);
        send(16'h0010, 32'h0000_1234);
        reg_rd(tail_a(4), rd); chk("R7 disabled tail", rd, 32'h0);
        reg_rd(17'h20C, rd);   chk("R7 disabled ovf", rd, 32'h10);
        reg_wr(17'h20C, 32'h10);

        // multi-region mode (R2, R4)
        reg_wr(ctrl_a(4), 32'h803);
        multi_region = 1'b1;
        send(16'h4000, 32'h0000_05A5);
        reg_rd(tail_a(4), rd); chk("R2 multi group4", rd, 32'h1);
        reg_rd(memaddr(1, 4, 0, 0), rd); chk("R4 multi window", rd, 32'h0000_05A5);
        send(16'h0004, 32'h0000_0066);
        reg_rd(tail_a(0), rd); chk("R2 multi group0", rd, 32'h3);
        reg_rd(memaddr(1, 0, 2, 0), rd); chk("R4 multi slot2", rd, 32'h0000_0066);
        send(16'h6000, 32'h0000_0099);
        reg_rd(tail_a(4), rd); chk("R2 multi drop", rd, 32'h1);
        reg_rd(17'h20C, rd);   chk("R2 multi drop ovf", rd, 32'h0);
        reg_rd({2'b10, 15'h4100}, rd); chk("R4 out of page", rd, 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule